// File: doc/BRIEF.md
# Two-Level Address-Space-Tagged Data Translation Buffer

This block translates virtual addresses for a single load/store port. It has two levels. The first level is small and fully associative, and one array in it holds 4 KB, 2 MB and 4 MB pages. The second level is larger and set associative, and it holds only 4 KB pages. Every entry stores an address space number. A lookup hits only when that number equals the current one, so translations from several address spaces stay cached across a context switch.

A requester presents a 48-bit virtual address while `lkp_ready` is high. One cycle later the block returns a registered result: hit or miss, the 40-bit physical address, and which level supplied the translation.

- **First-level miss, second-level hit.** The block answers with the same latency and copies the translation into the first level.
- **Miss in both levels.** The block reports a miss and raises a walk request that carries the address and the address space number. It then stalls further lookups until an external walker answers with a fill. The fill is written into both levels and the requester retries.

Two flush inputs are provided. One invalidates everything. The other invalidates only the entries of one address space.

Top module: `tlb_dual`

## Requirements
- R1: After reset no result and no walk request are signalled, `lkp_ready` is high, and every entry of both levels is invalid, so the first lookup misses.
- R2: A lookup accepted in cycle T (`lkp_valid` and `lkp_ready`, no flush input high) yields `res_valid` in cycle T+1. On a first-level hit it also yields `res_hit`=1, `res_from_l2`=0, and `res_pa` = {stored page frame, VA[11:0]}. `res_pa` is zero unless the result is a hit.
- R3: A hit requires the stored address space number to equal `cur_asn`. The same virtual page can be held under different address space numbers with different frames.
- R4: Fill size codes are 0 for 4 KB, 1 for 2 MB and 2 for 4 MB. A 2 MB entry matches while ignoring VA[20:12] and returns {frame[27:9], VA[20:0]}. A 4 MB entry matches while ignoring VA[21:12] and returns {frame[27:10], VA[21:0]}.
- R5: A lookup that misses the first level and hits the second returns `res_hit`=1 and `res_from_l2`=1 with the same one-cycle latency. It also loads the translation into the first level, so a repeat lookup reports `res_from_l2`=0.
- R6: A lookup that misses both levels returns `res_hit`=0. In the same cycle it raises `walk_req` with `walk_va` and `walk_asn` equal to the missed lookup. These are held, and `lkp_ready` stays low (lookups ignored), until a fill is taken.
- R7: `fill_valid` while `walk_req` is high ends the walk in the next cycle. It writes the translation into the first level, and into the second level only when the size is 4 KB. `fill_valid` while no walk is pending has no effect.
- R8: A first-level write uses the lowest-numbered invalid entry. If none is invalid, it uses a round-robin pointer that starts at 0 after reset and advances by one on each such use, wrapping after the last entry.
- R9: The second level selects its set with VA[18:12]. A write uses the lowest invalid way of that set, otherwise a per-set round-robin way pointer.
- R10: `flush_all` invalidates every entry of both levels. `flush_asn_en` invalidates only entries whose number equals `flush_asn`. A lookup presented in a flush cycle is dropped and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asn | input | 8 | Current address space number |
| lkp_valid | input | 1 | Lookup request |
| lkp_va | input | 48 | Lookup virtual address |
| lkp_ready | output | 1 | Lookups accepted (low while a walk is pending) |
| res_valid | output | 1 | Result of the lookup accepted last cycle |
| res_hit | output | 1 | Translation found |
| res_from_l2 | output | 1 | Translation came from the second level |
| res_pa | output | 40 | Physical address (zero unless hit) |
| walk_req | output | 1 | Table walk pending |
| walk_va | output | 48 | Virtual address to walk |
| walk_asn | output | 8 | Address space number of the walk |
| fill_valid | input | 1 | Walk response |
| fill_ppn | input | 28 | Physical page frame (PA[39:12]) |
| fill_size | input | 2 | Page size code (0 4 KB, 1 2 MB, 2 4 MB) |
| flush_all | input | 1 | Invalidate all entries |
| flush_asn_en | input | 1 | Invalidate entries of one address space |
| flush_asn | input | 8 | Address space number to invalidate |

## Verification
The hardest situation to reach from the ports is a translation that has left the first level but remains in the second, or that has been evicted from the second level while its first-level copy is also gone.

The stimulus first loads more distinct pages than the first level can hold, so the round-robin pointer recycles early entries. It then fills more than four pages that share one second-level set index. After that it churns the first level with pages of another address space, so that lookups of the conflicting pages expose which second-level ways survived.

Large pages are evicted in the same churn. This shows that they were never written to the second level.

// File: rtl/tlb_pkg.sv
// Shared constants and the page-size encoding for the two-level translation buffer.
package tlb_pkg;
    localparam int PG_SH  = 12;   // 4 KB page offset bits
    localparam int SH_2M  = 9;    // VPN bits ignored by a 2 MB entry
    localparam int SH_4M  = 10;   // VPN bits ignored by a 4 MB entry

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2
    } pg_sz_e;
endpackage

// File: rtl/tlb_l1_fa.sv
// First level: fully associative array of mixed-size entries.
// Compares every entry against the lookup in parallel, masking the low
// VPN bits according to each entry's own page size, and merges the
// untranslated VPN bits into the returned frame for large pages.
// Assumes VPN_W >= PPN_W >= 10 and at most one entry matching a lookup.
module tlb_l1_fa
    import tlb_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int PPN_W = 28,
    parameter int ASN_W = 8,
    parameter int N     = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             hit,
    output logic [N-1:0]     hitv,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [ASN_W-1:0] wr_asn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  pg_sz_e           wr_sz,
    input  logic             fl_all,
    input  logic             fl_asn_en,
    input  logic [ASN_W-1:0] fl_asn
);
    localparam int IW = $clog2(N);

    logic [N-1:0]     v_q;
    logic [ASN_W-1:0] asn_q [N];
    logic [VPN_W-1:0] vpn_q [N];
    logic [PPN_W-1:0] ppn_q [N];
    pg_sz_e           sz_q  [N];
    logic [IW-1:0]    rr_q;
    logic             free_found;
    logic [IW-1:0]    free_idx;
    logic [IW-1:0]    victim;

    function automatic logic [VPN_W-1:0] vmask(pg_sz_e s);
        logic [VPN_W-1:0] m;
        m = '1;
        case (s)
            PG_2M:   m[SH_2M-1:0] = '0;
            PG_4M:   m[SH_4M-1:0] = '0;
            default: ;
        endcase
        return m;
    endfunction

    function automatic logic [PPN_W-1:0] pmask(pg_sz_e s);
        logic [PPN_W-1:0] m;
        m = '1;
        case (s)
            PG_2M:   m[SH_2M-1:0] = '0;
            PG_4M:   m[SH_4M-1:0] = '0;
            default: ;
        endcase
        return m;
    endfunction

    // Per-entry match: valid, same address space, page bits equal under size mask.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            hitv[i] = v_q[i] && (asn_q[i] == lk_asn)
                   && (((vpn_q[i] ^ lk_vpn) & vmask(sz_q[i])) == '0);
        end
    end

    assign hit = |hitv;

    // Frame of the matching entry with in-page VPN bits taken from the lookup.
    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < N; i++) begin
            if (hitv[i]) begin
                hit_ppn = (ppn_q[i] & pmask(sz_q[i]))
                        | (lk_vpn[PPN_W-1:0] & ~pmask(sz_q[i]));
            end
        end
    end

    // Lowest-numbered invalid entry, if any.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!v_q[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    assign victim = free_found ? free_idx : rr_q;

    // Valid bits and victim pointer: flush first, then the write wins its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= '0;
            rr_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (fl_all) begin
                    v_q[i] <= 1'b0;
                end else if (fl_asn_en && (asn_q[i] == fl_asn)) begin
                    v_q[i] <= 1'b0;
                end
                if (wr_en && (victim == IW'(i))) begin
                    v_q[i] <= 1'b1;
                end
            end
            if (wr_en && !free_found) begin
                rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
            end
        end
    end

    // Entry payload, written into the chosen victim slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            asn_q[victim] <= wr_asn;
            vpn_q[victim] <= wr_vpn;
            ppn_q[victim] <= wr_ppn;
            sz_q[victim]  <= wr_sz;
        end
    end
endmodule

// File: rtl/tlb_l2_sa.sv
// Second level: set-associative array of 4 KB entries.
// The set is chosen by the low VPN bits; each set keeps its own
// round-robin way pointer used once all its ways are valid.
// Assumes WAYS >= 2 and SETS a power of two.
module tlb_l2_sa #(
    parameter int VPN_W = 36,
    parameter int PPN_W = 28,
    parameter int ASN_W = 8,
    parameter int SETS  = 128,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             hit,
    output logic [WAYS-1:0]  hitv,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [ASN_W-1:0] wr_asn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             fl_all,
    input  logic             fl_asn_en,
    input  logic [ASN_W-1:0] fl_asn
);
    localparam int SW    = $clog2(SETS);
    localparam int WW    = $clog2(WAYS);
    localparam int TAG_W = VPN_W - SW;

    logic [WAYS-1:0]  v_q   [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [ASN_W-1:0] asn_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [WW-1:0]    rr_q  [SETS];

    logic [SW-1:0]    lk_set, wr_set;
    logic [TAG_W-1:0] lk_tag;
    logic             free_found;
    logic [WW-1:0]    free_way, victim;

    assign lk_set = lk_vpn[SW-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SW];
    assign wr_set = wr_vpn[SW-1:0];

    // Way match within the indexed set and frame selection.
    always_comb begin
        hit_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            hitv[w] = v_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)
                   && (asn_q[lk_set][w] == lk_asn);
            if (hitv[w]) begin
                hit_ppn = ppn_q[lk_set][w];
            end
        end
    end

    assign hit = |hitv;

    // Lowest invalid way of the set being written.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!v_q[wr_set][w]) begin
                free_found = 1'b1;
                free_way   = WW'(w);
            end
        end
    end

    assign victim = free_found ? free_way : rr_q[wr_set];

    // Valid bits and per-set pointers: flush first, then the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                v_q[s]  <= '0;
                rr_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (fl_all) begin
                        v_q[s][w] <= 1'b0;
                    end else if (fl_asn_en && (asn_q[s][w] == fl_asn)) begin
                        v_q[s][w] <= 1'b0;
                    end
                end
            end
            if (wr_en) begin
                v_q[wr_set][victim] <= 1'b1;
                if (!free_found) begin
                    rr_q[wr_set] <= rr_q[wr_set] + WW'(1);
                end
            end
        end
    end

    // Entry payload of the chosen way.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][victim] <= wr_vpn[VPN_W-1:SW];
            asn_q[wr_set][victim] <= wr_asn;
            ppn_q[wr_set][victim] <= wr_ppn;
        end
    end
endmodule

// File: rtl/tlb_dual.sv
// Two-level address-space-tagged data translation buffer for one port.
// Both levels are searched in the same cycle; the result is registered.
// A double miss raises one outstanding walk and stalls lookups until the
// fill arrives. Assumes the page tables never map one address twice.
module tlb_dual
    import tlb_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PA_W       = 40,
    parameter int ASN_W      = 8,
    parameter int L1_ENTRIES = 40,
    parameter int L2_SETS    = 128,
    parameter int L2_WAYS    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ASN_W-1:0]      cur_asn,
    input  logic                  lkp_valid,
    input  logic [VA_W-1:0]       lkp_va,
    output logic                  lkp_ready,
    output logic                  res_valid,
    output logic                  res_hit,
    output logic                  res_from_l2,
    output logic [PA_W-1:0]       res_pa,
    output logic                  walk_req,
    output logic [VA_W-1:0]       walk_va,
    output logic [ASN_W-1:0]      walk_asn,
    input  logic                  fill_valid,
    input  logic [PA_W-PG_SH-1:0] fill_ppn,
    input  logic [1:0]            fill_size,
    input  logic                  flush_all,
    input  logic                  flush_asn_en,
    input  logic [ASN_W-1:0]      flush_asn
);
    localparam int VPN_W = VA_W - PG_SH;
    localparam int PPN_W = PA_W - PG_SH;

    logic [VPN_W-1:0]      lk_vpn;
    logic [PG_SH-1:0]      lk_off;
    logic                  acc, fill_take;
    logic                  l1_hit, l2_hit;
    logic [L1_ENTRIES-1:0] l1_hitv;
    logic [L2_WAYS-1:0]    l2_hitv;
    logic [PPN_W-1:0]      l1_ppn, l2_ppn;
    logic                  l1_wr, l2_wr;
    logic [VPN_W-1:0]      l1_wr_vpn;
    logic [ASN_W-1:0]      l1_wr_asn;
    logic [PPN_W-1:0]      l1_wr_ppn;
    pg_sz_e                l1_wr_sz;

    logic                  walk_q;
    logic [VA_W-1:0]       wva_q;
    logic [ASN_W-1:0]      wasn_q;
    logic                  rv_q, rh_q, rl2_q;
    logic [PA_W-1:0]       rpa_q;

    assign lk_vpn    = lkp_va[VA_W-1:PG_SH];
    assign lk_off    = lkp_va[PG_SH-1:0];
    assign lkp_ready = !walk_q;
    assign acc       = lkp_valid && !walk_q && !flush_all && !flush_asn_en;
    assign fill_take = walk_q && fill_valid;

    // First-level write source: walk fill, else reload from the second level.
    always_comb begin
        l1_wr = fill_take || (acc && !l1_hit && l2_hit);
        if (fill_take) begin
            l1_wr_vpn = wva_q[VA_W-1:PG_SH];
            l1_wr_asn = wasn_q;
            l1_wr_ppn = fill_ppn;
            l1_wr_sz  = pg_sz_e'(fill_size);
        end else begin
            l1_wr_vpn = lk_vpn;
            l1_wr_asn = cur_asn;
            l1_wr_ppn = l2_ppn;
            l1_wr_sz  = PG_4K;
        end
    end

    assign l2_wr = fill_take && (pg_sz_e'(fill_size) == PG_4K);

    tlb_l1_fa #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .N(L1_ENTRIES)
    ) u_l1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .lk_asn   (cur_asn),
        .hit      (l1_hit),
        .hitv     (l1_hitv),
        .hit_ppn  (l1_ppn),
        .wr_en    (l1_wr),
        .wr_vpn   (l1_wr_vpn),
        .wr_asn   (l1_wr_asn),
        .wr_ppn   (l1_wr_ppn),
        .wr_sz    (l1_wr_sz),
        .fl_all   (flush_all),
        .fl_asn_en(flush_asn_en),
        .fl_asn   (flush_asn)
    );

    tlb_l2_sa #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W),
        .SETS(L2_SETS), .WAYS(L2_WAYS)
    ) u_l2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .lk_asn   (cur_asn),
        .hit      (l2_hit),
        .hitv     (l2_hitv),
        .hit_ppn  (l2_ppn),
        .wr_en    (l2_wr),
        .wr_vpn   (wva_q[VA_W-1:PG_SH]),
        .wr_asn   (wasn_q),
        .wr_ppn   (fill_ppn),
        .fl_all   (flush_all),
        .fl_asn_en(flush_asn_en),
        .fl_asn   (flush_asn)
    );

    // Registered lookup result and single outstanding walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q   <= 1'b0;
            rh_q   <= 1'b0;
            rl2_q  <= 1'b0;
            rpa_q  <= '0;
            walk_q <= 1'b0;
            wva_q  <= '0;
            wasn_q <= '0;
        end else begin
            rv_q  <= acc;
            rh_q  <= acc && (l1_hit || l2_hit);
            rl2_q <= acc && !l1_hit && l2_hit;
            if (acc && l1_hit) begin
                rpa_q <= {l1_ppn, lk_off};
            end else if (acc && l2_hit) begin
                rpa_q <= {l2_ppn, lk_off};
            end else begin
                rpa_q <= '0;
            end
            if (fill_take) begin
                walk_q <= 1'b0;
            end else if (acc && !l1_hit && !l2_hit) begin
                walk_q <= 1'b1;
                wva_q  <= lkp_va;
                wasn_q <= cur_asn;
            end
        end
    end

    assign res_valid   = rv_q;
    assign res_hit     = rh_q;
    assign res_from_l2 = rl2_q;
    assign res_pa      = rpa_q;
    assign walk_req    = walk_q;
    assign walk_va     = wva_q;
    assign walk_asn    = wasn_q;
endmodule

// File: rtl/tlb_dual_chk.sv
// Protocol and structure checks for tlb_dual, attached by bind.
module tlb_dual_chk #(
    parameter int VA_W       = 48,
    parameter int ASN_W      = 8,
    parameter int L1_ENTRIES = 40,
    parameter int L2_WAYS    = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lkp_valid,
    input logic                  lkp_ready,
    input logic                  res_valid,
    input logic                  res_hit,
    input logic                  res_from_l2,
    input logic                  walk_req,
    input logic [VA_W-1:0]       walk_va,
    input logic [ASN_W-1:0]      walk_asn,
    input logic                  fill_valid,
    input logic                  flush_all,
    input logic                  flush_asn_en,
    input logic [L1_ENTRIES-1:0] l1_hitv,
    input logic [L2_WAYS-1:0]    l2_hitv
);
    // R2: at most one first-level entry matches any lookup
    p_l1_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l1_hitv));

    // R9: at most one way of a set matches
    p_l2_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l2_hitv));

    // R2: an accepted lookup is answered in the next cycle
    p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_ready && !flush_all && !flush_asn_en) |=> res_valid);

    // R5: second-level source only on a reported hit
    p_src_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_from_l2 |-> (res_valid && res_hit));

    // R6: a reported miss comes with a pending walk
    p_miss_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> walk_req);

    // R6: lookups stall during a walk
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !lkp_ready);

    // R6: walk request held stable until a fill
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=>
        (walk_req && $stable(walk_va) && $stable(walk_asn)));

    // R7: a fill ends the walk
    p_fill_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> !walk_req);

    // R10: a lookup in a flush cycle gives no result
    p_flush_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all || flush_asn_en) |=> !res_valid);
endmodule

bind tlb_dual tlb_dual_chk #(
    .VA_W(VA_W), .ASN_W(ASN_W), .L1_ENTRIES(L1_ENTRIES), .L2_WAYS(L2_WAYS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lkp_valid   (lkp_valid),
    .lkp_ready   (lkp_ready),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_from_l2 (res_from_l2),
    .walk_req    (walk_req),
    .walk_va     (walk_va),
    .walk_asn    (walk_asn),
    .fill_valid  (fill_valid),
    .flush_all   (flush_all),
    .flush_asn_en(flush_asn_en),
    .l1_hitv     (l1_hitv),
    .l2_hitv     (l2_hitv)
);

// File: tb/tb_tlb_dual.sv
`timescale 1ns/1ps
// Bench: behavioural reference of both levels, compared on every clock.
module tb_tlb_dual;
    localparam int N1 = 40;
    localparam int NS = 128;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_asn = '0;
    logic        lkp_valid = 1'b0;
    logic [47:0] lkp_va = '0;
    logic        lkp_ready;
    logic        res_valid, res_hit, res_from_l2;
    logic [39:0] res_pa;
    logic        walk_req;
    logic [47:0] walk_va;
    logic [7:0]  walk_asn;
    logic        fill_valid = 1'b0;
    logic [27:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0;
    logic        flush_all = 1'b0;
    logic        flush_asn_en = 1'b0;
    logic [7:0]  flush_asn = '0;

    always #2.5 clk = ~clk;

    tlb_dual dut (.*);

    // Reference state
    bit          m1_v [N1];
    logic [7:0]  m1_a [N1];
    logic [35:0] m1_n [N1];
    logic [27:0] m1_p [N1];
    int          m1_s [N1];
    int          m1_rr;
    bit          m2_v [NS][NW];
    logic [7:0]  m2_a [NS][NW];
    logic [35:0] m2_n [NS][NW];
    logic [27:0] m2_p [NS][NW];
    int          m2_rr [NS];
    bit          m_walk;
    logic [47:0] m_wva;
    logic [7:0]  m_wasn;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int shift_of(int s);
        return (s == 1) ? 9 : (s == 2) ? 10 : 0;
    endfunction

    // Page table seen by the walker
    function automatic int pt_size(logic [47:0] va);
        if (va[47:40] == 8'hA0) return 1;
        if (va[47:40] == 8'hB0) return 2;
        return 0;
    endfunction

    function automatic logic [27:0] pt_ppn(logic [7:0] asn, logic [47:0] va);
        return va[39:12] ^ {asn, 20'h5A5A5};
    endfunction

    // One clock: drive inputs, predict, then compare after the edge.
    task automatic cyc(string tag, bit lv, logic [47:0] va, logic [7:0] asn,
                       bit fa, bit fae, logic [7:0] fasn,
                       bit fv, logic [27:0] fp, logic [1:0] fs);
        bit acc, take, w1, w2;
        int h1, h2, v1, v2, sh;
        int set_l, set_w;
        bit adv1, adv2;
        logic [35:0] vpn;
        logic [39:0] epa;
        logic [27:0] l2p;
        bit ehit, el2;

        lkp_valid = lv; lkp_va = va; cur_asn = asn;
        flush_all = fa; flush_asn_en = fae; flush_asn = fasn;
        fill_valid = fv; fill_ppn = fp; fill_size = fs;

        vpn = va[47:12];
        acc = lv && !m_walk && !fa && !fae;
        h1 = -1;
        for (int i = 0; i < N1; i++) begin
            sh = shift_of(m1_s[i]);
            if (m1_v[i] && m1_a[i] == asn && (m1_n[i] >> sh) == (vpn >> sh)) h1 = i;
        end
        set_l = int'(va[18:12]);
        h2 = -1;
        l2p = '0;
        for (int w = 0; w < NW; w++) begin
            if (m2_v[set_l][w] && m2_a[set_l][w] == asn && m2_n[set_l][w] == vpn) begin
                h2 = w;
                l2p = m2_p[set_l][w];
            end
        end
        ehit = acc && (h1 >= 0 || h2 >= 0);
        el2  = acc && h1 < 0 && h2 >= 0;
        epa  = '0;
        if (acc && h1 >= 0) begin
            sh = shift_of(m1_s[h1]);
            epa = {((m1_p[h1] >> sh) << sh) | (vpn[27:0] & ((28'd1 << sh) - 28'd1)), va[11:0]};
        end else if (acc && h2 >= 0) begin
            epa = {l2p, va[11:0]};
        end

        take = m_walk && fv;
        w1 = take || el2;
        v1 = -1;
        for (int i = N1 - 1; i >= 0; i--) if (!m1_v[i]) v1 = i;
        adv1 = (v1 < 0);
        if (adv1) v1 = m1_rr;
        w2 = take && fs == 2'd0;
        set_w = int'(m_wva[18:12]);
        v2 = -1;
        for (int w = NW - 1; w >= 0; w--) if (!m2_v[set_w][w]) v2 = w;
        adv2 = (v2 < 0);
        if (adv2) v2 = m2_rr[set_w];

        for (int i = 0; i < N1; i++)
            if (fa || (fae && m1_a[i] == fasn)) m1_v[i] = 0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                if (fa || (fae && m2_a[s][w] == fasn)) m2_v[s][w] = 0;

        if (w1) begin
            m1_v[v1] = 1;
            if (take) begin
                m1_a[v1] = m_wasn; m1_n[v1] = m_wva[47:12]; m1_p[v1] = fp; m1_s[v1] = int'(fs);
            end else begin
                m1_a[v1] = asn; m1_n[v1] = vpn; m1_p[v1] = l2p; m1_s[v1] = 0;
            end
            if (adv1) m1_rr = (m1_rr + 1) % N1;
        end
        if (w2) begin
            m2_v[set_w][v2] = 1; m2_a[set_w][v2] = m_wasn;
            m2_n[set_w][v2] = m_wva[47:12]; m2_p[set_w][v2] = fp;
            if (adv2) m2_rr[set_w] = (m2_rr[set_w] + 1) % NW;
        end

        if (take) m_walk = 0;
        else if (acc && h1 < 0 && h2 < 0) begin
            m_walk = 1; m_wva = va; m_wasn = asn;
        end

        @(posedge clk);
        #1;
        chk(tag, "res_valid", 64'(res_valid), 64'(acc));
        chk(tag, "res_hit", 64'(res_hit), 64'(ehit));
        chk(tag, "res_from_l2", 64'(res_from_l2), 64'(el2));
        chk(tag, "res_pa", 64'(res_pa), 64'(epa));
        chk(tag, "walk_req", 64'(walk_req), 64'(m_walk));
        chk(tag, "lkp_ready", 64'(lkp_ready), 64'(!m_walk));
        if (m_walk) begin
            chk(tag, "walk_va", 64'(walk_va), 64'(m_wva));
            chk(tag, "walk_asn", 64'(walk_asn), 64'(m_wasn));
        end
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, '0, cur_asn, 0, 0, '0, 0, '0, '0);
    endtask

    task automatic look(string tag, logic [47:0] va, logic [7:0] asn);
        cyc(tag, 1, va, asn, 0, 0, '0, 0, '0, '0);
    endtask

    // Act as the walker for a pending request.
    task automatic walk_fill(string tag);
        if (m_walk) begin
            idle(tag);
            idle(tag);
            cyc(tag, 0, '0, cur_asn, 0, 0, '0, 1, pt_ppn(m_wasn, m_wva),
                2'(pt_size(m_wva)));
        end
    endtask

    task automatic xlate(string tag, logic [47:0] va, logic [7:0] asn);
        look(tag, va, asn);
        walk_fill(tag);
    endtask

    localparam logic [47:0] VA_A = 48'h0000_1234_5678;

    initial begin
        for (int i = 0; i < N1; i++) begin
            m1_v[i] = 0; m1_a[i] = '0; m1_n[i] = '0; m1_p[i] = '0; m1_s[i] = 0;
        end
        for (int s = 0; s < NS; s++) begin
            m2_rr[s] = 0;
            for (int w = 0; w < NW; w++) begin
                m2_v[s][w] = 0; m2_a[s][w] = '0; m2_n[s][w] = '0; m2_p[s][w] = '0;
            end
        end
        m1_rr = 0; m_walk = 0; m_wva = '0; m_wasn = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1", "res_valid", 64'(res_valid), 64'd0);
        chk("R1", "walk_req", 64'(walk_req), 64'd0);
        chk("R1", "lkp_ready", 64'(lkp_ready), 64'd1);
        look("R1", VA_A, 8'd5);
        chk("R1", "first lookup hit", 64'(res_hit), 64'd0);
        // R6: lookup while walking is ignored
        look("R6", 48'h0000_0000_9000, 8'd5);
        walk_fill("R7");
        // R2: first-level hits, different offsets
        look("R2", VA_A, 8'd5);
        chk("R2", "hit", 64'(res_hit), 64'd1);
        look("R2", VA_A ^ 48'hFFF, 8'd5);
        // R3: same page, other address space
        xlate("R3", VA_A, 8'd6);
        look("R3", VA_A, 8'd6);
        look("R3", VA_A, 8'd5);
        look("R3", VA_A, 8'd7);
        walk_fill("R3");
        // R4: 2 MB and 4 MB pages
        xlate("R4", 48'hA000_1220_0345, 8'd5);
        look("R4", 48'hA000_123F_FF00, 8'd5);
        chk("R4", "2M hit", 64'(res_hit), 64'd1);
        xlate("R4", 48'hB000_0040_0123, 8'd5);
        look("R4", 48'hB000_007F_FFFC, 8'd5);
        chk("R4", "4M hit", 64'(res_hit), 64'd1);
        xlate("R4", 48'hB000_0080_0000, 8'd5);
        // R7: stray fill has no effect
        cyc("R7", 0, '0, 8'd5, 0, 0, '0, 1, 28'h123_4567, 2'd0);
        xlate("R7", 48'h0000_0000_7000, 8'd5);
        // R8: overflow first level, round-robin replacement
        for (int k = 0; k < 45; k++) xlate("R8", 48'h0000_0100_0000 + (48'(k) << 12), 8'd1);
        xlate("R5", VA_A, 8'd5);
        look("R5", VA_A, 8'd5);
        xlate("R8", 48'hA000_1220_0000, 8'd5);
        for (int k = 0; k < 8; k++) xlate("R5", 48'h0000_0100_0000 + (48'(k) << 12), 8'd1);
        // R9: six pages in one second-level set, then churn first level
        for (int k = 1; k <= 6; k++) xlate("R9", 48'h0000_0000_3000 | (48'(k) << 19), 8'd2);
        for (int k = 0; k < 42; k++) xlate("R9", 48'h0000_0200_0000 + (48'(k) << 12), 8'd3);
        for (int k = 1; k <= 6; k++) xlate("R9", 48'h0000_0000_3000 | (48'(k) << 19), 8'd2);
        // R10: flush by address space, then everything, then lookup during flush
        cyc("R10", 0, '0, 8'd1, 0, 1, 8'd1, 0, '0, '0);
        xlate("R10", 48'h0000_0100_0000 + (48'd40 << 12), 8'd1);
        xlate("R10", 48'h0000_0200_0000 + (48'd41 << 12), 8'd3);
        cyc("R10", 1, VA_A, 8'd5, 1, 0, '0, 0, '0, '0);
        xlate("R10", VA_A, 8'd5);
        xlate("R10", 48'h0000_0200_0000 + (48'd41 << 12), 8'd3);
        idle("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule